// File: doc/BRIEF.md
# Wall-Following Maze Robot Controller

This block steers a small maze robot so that it keeps a wall on its right-hand side. Two binary touch sensors, one on a left antenna and one on a right antenna, read 1 while they press against a wall and 0 otherwise. When both sensors read 1, a wall lies straight ahead. On every rising clock edge the controller samples both sensors and moves to a new state. It then issues any combination of three movement commands: step forward, turn slightly right and turn slightly left.

The controller is a Moore machine with four states. SEEK means the robot is lost and drives straight until it touches something. PIVOT turns the robot left, away from a wall ahead. HUG follows the wall while touching it. DRIFT follows the wall without touching it, and also handles a break in the wall. The commands are decoded from the stored state alone, so a change on a sensor reaches the motors one clock later at the earliest. The state is held in two bits with a fixed code, and that code is also driven out so that it can be observed. The sensors and commands are plain level signals with no handshake, because a command is produced every cycle.

Top module: `wall_tracker`

## Requirements
- R1: While `rst_i` is high at a rising edge, the state becomes SEEK (code 2'b00), so the next outputs are `mode_o`=2'b00 and `cmd_o`=3'b100 (forward only). This applies from any state.
- R2: In SEEK, the state stays SEEK when both sensors read 0. It moves to PIVOT when either sensor reads 1.
- R3: In PIVOT, the state stays PIVOT while at least one sensor reads 1. It moves to DRIFT when both sensors read 0.
- R4: In HUG, left=0 with right=0 leads to DRIFT, and left=0 with right=1 keeps the state at HUG.
- R5: In DRIFT, left=0 with right=0 keeps the state at DRIFT, and left=0 with right=1 leads to HUG.
- R6: `cmd_o` is ordered {forward, turn-right, turn-left}. It reads 3'b100 in SEEK, 3'b001 in PIVOT, 3'b101 in HUG and 3'b110 in DRIFT.
- R7: `mode_o` carries the state code: SEEK=2'b00, PIVOT=2'b01, HUG=2'b10, DRIFT=2'b11.
- R8: The commands depend only on the current state. A sensor change between clock edges leaves `cmd_o` unchanged until the next edge.
- R9: In HUG or DRIFT, the left sensor reading 1 leads to PIVOT, whatever the right sensor reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; sensors are sampled on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset into SEEK |
| touch_l_i | input | 1 | Left antenna touch sensor, 1 = touching a wall |
| touch_r_i | input | 1 | Right antenna touch sensor, 1 = touching a wall |
| cmd_o | output | 3 | Movement commands {forward, turn-right, turn-left} |
| mode_o | output | 2 | Current state code |

## Verification
The bench steers the controller into each of the four states and applies all four sensor combinations from each one. A design with a swapped arc, for example HUG staying put on an open wall or PIVOT leaving while one antenna still touches, shows the wrong `mode_o` right after the edge. Left-over-right priority in the two following states is probed with both sensors set. A design that let the right sensor win would return to HUG instead of pivoting. Sensors are toggled in mid-cycle to catch a Mealy-style leak into `cmd_o`. A long pseudo-random walk with resets inserted mid-run catches a reset that does not take effect from every state.

// File: rtl/wall_tracker_pkg.sv
package wall_tracker_pkg;
  localparam int unsigned STATE_W = 2;
  localparam int unsigned CMD_W   = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_SEEK  = 2'b00,
    ST_PIVOT = 2'b01,
    ST_HUG   = 2'b10,
    ST_DRIFT = 2'b11
  } trk_state_e;

  typedef struct packed {
    logic fwd;
    logic right;
    logic left;
  } trk_cmd_t;
endpackage

// File: rtl/wall_tracker_next.sv
module wall_tracker_next
  import wall_tracker_pkg::*;
(
  input  trk_state_e cur_i,
  input  logic       left_i,
  input  logic       right_i,
  output trk_state_e nxt_o
);
  logic any_touch;
  assign any_touch = left_i | right_i;

  always_comb begin
    nxt_o = cur_i;
    case (cur_i)
      ST_SEEK:  nxt_o = any_touch ? ST_PIVOT : ST_SEEK;
      ST_PIVOT: nxt_o = any_touch ? ST_PIVOT : ST_DRIFT;
      ST_HUG, ST_DRIFT: begin
        if (left_i)       nxt_o = ST_PIVOT;
        else if (right_i) nxt_o = ST_HUG;
        else              nxt_o = ST_DRIFT;
      end
      default: nxt_o = ST_SEEK;
    endcase
  end
endmodule

// File: rtl/wall_tracker_decode.sv
module wall_tracker_decode
  import wall_tracker_pkg::*;
(
  input  trk_state_e cur_i,
  output trk_cmd_t   cmd_o
);
  always_comb begin
    cmd_o = '{fwd: 1'b1, right: 1'b0, left: 1'b0};
    case (cur_i)
      ST_SEEK:  cmd_o = '{fwd: 1'b1, right: 1'b0, left: 1'b0};
      ST_PIVOT: cmd_o = '{fwd: 1'b0, right: 1'b0, left: 1'b1};
      ST_HUG:   cmd_o = '{fwd: 1'b1, right: 1'b0, left: 1'b1};
      ST_DRIFT: cmd_o = '{fwd: 1'b1, right: 1'b1, left: 1'b0};
      default:  cmd_o = '{fwd: 1'b1, right: 1'b0, left: 1'b0};
    endcase
  end
endmodule

// File: rtl/wall_tracker_reg.sv
module wall_tracker_reg
  import wall_tracker_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  trk_state_e nxt_i,
  output trk_state_e cur_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) cur_o <= ST_SEEK;
    else       cur_o <= nxt_i;
  end
endmodule

// File: rtl/wall_tracker.sv
module wall_tracker
  import wall_tracker_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               touch_l_i,
  input  logic               touch_r_i,
  output logic [CMD_W-1:0]   cmd_o,
  output logic [STATE_W-1:0] mode_o
);
  trk_state_e cur_q;
  trk_state_e nxt_d;
  trk_cmd_t   cmd_d;

  wall_tracker_next u_next (
    .cur_i   (cur_q),
    .left_i  (touch_l_i),
    .right_i (touch_r_i),
    .nxt_o   (nxt_d)
  );

  wall_tracker_reg u_reg (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .nxt_i (nxt_d),
    .cur_o (cur_q)
  );

  wall_tracker_decode u_dec (
    .cur_i (cur_q),
    .cmd_o (cmd_d)
  );

  assign cmd_o  = cmd_d;
  assign mode_o = cur_q;
endmodule

// File: rtl/wall_tracker_chk.sv
module wall_tracker_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       touch_l_i,
  input logic       touch_r_i,
  input logic [2:0] cmd_o,
  input logic [1:0] mode_o
);
  // R1
  reset_seek_chk: assert property (@(posedge clk_i)
    rst_i |=> (mode_o == 2'b00 && cmd_o == 3'b100));

  // R2
  seek_exit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_o == 2'b00 && (touch_l_i || touch_r_i)) |=> mode_o == 2'b01);

  // R3
  pivot_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_o == 2'b01 && (touch_l_i || touch_r_i)) |=> mode_o == 2'b01);

  // R9
  left_priority_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_o[1] && touch_l_i) |=> mode_o == 2'b01);

  // R5
  drift_to_hug_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_o == 2'b11 && !touch_l_i && touch_r_i) |=> mode_o == 2'b10);

  // R6
  pivot_cmd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    mode_o == 2'b01 |-> cmd_o == 3'b001);

  // R8
  moore_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $stable(mode_o) |-> $stable(cmd_o));
endmodule

bind wall_tracker wall_tracker_chk u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .touch_l_i (touch_l_i),
  .touch_r_i (touch_r_i),
  .cmd_o     (cmd_o),
  .mode_o    (mode_o)
);

// File: tb/wall_tracker_tb_top.sv
module wall_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tl  = 1'b0;
  logic       tr  = 1'b0;
  logic [2:0] cmd;
  logic [1:0] mode;
  int         checks = 0;
  int         fails  = 0;
  logic [1:0] exp_st = 2'b00;

  always #4 clk = ~clk;

  wall_tracker dut_i (
    .clk_i     (clk),
    .rst_i     (rst),
    .touch_l_i (tl),
    .touch_r_i (tr),
    .cmd_o     (cmd),
    .mode_o    (mode)
  );

  function automatic logic [1:0] ref_next(logic [1:0] s, logic l, logic r);
    case (s)
      2'd0:    return (l || r) ? 2'd1 : 2'd0;
      2'd1:    return (l || r) ? 2'd1 : 2'd3;
      default: return l ? 2'd1 : (r ? 2'd2 : 2'd3);
    endcase
  endfunction

  function automatic logic [2:0] ref_cmd(logic [1:0] s);
    case (s)
      2'd0:    return 3'b100;
      2'd1:    return 3'b001;
      2'd2:    return 3'b101;
      default: return 3'b110;
    endcase
  endfunction

  function automatic string arc_tag(logic [1:0] s, logic l);
    case (s)
      2'd0:    return "R2";
      2'd1:    return "R3";
      2'd2:    return l ? "R9" : "R4";
      default: return l ? "R9" : "R5";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tl = 1'b0; tr = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    exp_st = 2'b00;
    check("R1 mode", {30'd0, mode}, 32'd0);
    check("R1 cmd", {29'd0, cmd}, 32'h4);
  endtask

  task automatic step(logic l, logic r);
    string t;
    t = arc_tag(exp_st, l);
    tl = l; tr = r;
    #1;
    check("R8 cmd before edge", {29'd0, cmd}, {29'd0, ref_cmd(exp_st)});
    @(negedge clk);
    exp_st = ref_next(exp_st, l, r);
    check({t, "/R7 mode"}, {30'd0, mode}, {30'd0, exp_st});
    check("R6 cmd", {29'd0, cmd}, {29'd0, ref_cmd(exp_st)});
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    @(negedge clk);
    do_reset();
    // exhaustive sweep: every state x every sensor pair
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 4; v++) begin
        do_reset();
        if (s != 0) step(1'b1, 1'b0);
        if (s >= 2) step(1'b0, 1'b0);
        if (s == 2) step(1'b0, 1'b1);
        check("R7 reached", {30'd0, mode}, s);
        step(v[1], v[0]);
      end
    end
    // R1 from each non-seek state
    for (int s = 1; s < 4; s++) begin
      do_reset();
      step(1'b1, 1'b0);
      if (s >= 2) step(1'b0, 1'b0);
      if (s == 2) step(1'b0, 1'b1);
      do_reset();
    end
    // pseudo-random walk with occasional resets
    lfsr = 8'hA5;
    do_reset();
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (lfsr[7:3] == 5'd0) do_reset();
      else step(lfsr[1], lfsr[0]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule